// File: doc/BRIEF.md
# Prescaled Interval Timer with Watchdog Mode

This block is one timer channel driven by the bus clock and controlled through a small register port. A 16-bit divider turns the clock into ticks, and a 16-bit period counter counts those ticks. When the counter reaches its programmed period it raises an expiry flag. In periodic mode it then restarts at once. In one-shot mode it stops and clears its own enable bit. The flag can drive an interrupt line.

Setting the watchdog bit turns the same counter into a watchdog. Software keeps it alive by writing the service key 0xA5 into the top byte of the mode word. If the countdown runs out first, the block pulses a reset output for one clock. Once the watchdog is armed, software can no longer switch it off; only a reset of the block does that. The register port is plain: a write strobe, byte enables, a word address, write data, and combinational read data for the addressed word.

Top module: `ptimer_wdt`

## Requirements
- R1: After reset, the mode (address 0), count (address 1) and status (address 2) words all read zero, and `irq` and `wdt_rst` are low.
- R2: The count word holds the divider value D in bits 31:16 and the period P in bits 15:0. An expiry sets status bit 0 exactly D*P clocks after the clock edge that restarted the countdown.
- R3: A divider value of 0 divides by 65536, and a period of 0 counts 65536 ticks. A divider value of 1 means no division.
- R4: With mode bit 10 (periodic) set, an expiry restarts the countdown at once, so the next expiry follows another D*P clocks later.
- R5: With mode bit 10 clear, an expiry clears mode bit 12 (enable), and no further expiry happens.
- R6: Mode bit 12 enables counting. Clearing it stops the timer, and no expiry follows.
- R7: A write to the count word, a 0-to-1 write of the enable bit, or an accepted service write restarts the countdown from zero.
- R8: Status bits are write-one-to-clear through byte 0: bit 0 is expiry and bit 1 is watchdog bite. Writing a 0 to a bit leaves it unchanged.
- R9: `irq` equals status bit 0 AND mode bit 8 (interrupt enable) AND NOT mode bit 15 (watchdog).
- R10: While mode bits 15 and 12 are set, a mode write with byte enable 3 and data bits 31:24 equal to 0xA5 restarts the countdown. Any other value in that byte has no effect.
- R11: When the countdown expires in watchdog mode, `wdt_rst` is high for exactly one clock, starting D*P clocks after the last restart. Status bit 1 is set and mode bit 12 clears.
- R12: Once mode bits 15 and 12 have both been set, writes cannot clear bit 15 or bit 12 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| byte_en | input | 4 | Byte enables for the write |
| addr | input | 2 | Word address: 0 mode, 1 count, 2 status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word (combinational) |
| irq | output | 1 | Expiry interrupt |
| wdt_rst | output | 1 | One-clock reset pulse on watchdog bite |

## Verification
The situations hardest to reach from the ports are the two zero encodings and the service-versus-bite race. A zero divider or a zero period needs a 65536-clock countdown, so each is run once as a directed one-shot case. The bench checks the flag on the clock before the expiry and on the clock of the expiry. For the watchdog, the key is written repeatedly on the last clock before the bite would happen, and no reset pulse may appear. Then an attempt to disarm the watchdog and a wrong-key write are issued, and the bite must land exactly D*P clocks after the last valid service. Random divider and period pairs, in both one-shot and periodic mode and with the interrupt enable on and off, cover the general timing.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam logic [1:0] A_MODE  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_STAT  = 2'd2;
  localparam int B_IRQEN = 8;
  localparam int B_CONT  = 10;
  localparam int B_EN    = 12;
  localparam int B_WDT   = 15;
  localparam logic [7:0] SVC_KEY = 8'hA5;
  localparam int ST_W    = 4;
  localparam int ST_EXP  = 0;
  localparam int ST_BITE = 1;

  typedef struct packed {
    logic wdt;
    logic en;
    logic cont;
    logic irqen;
  } mode_t;
endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         clear,
  input  logic [W-1:0] div_val,
  output logic         tick
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] term;

  // zero selects the widest division, 2**W
  assign term = (div_val == '0) ? '1 : div_val - 1'b1;
  assign tick = run & ~clear & (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (run)    cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ptimer_period.sv
module ptimer_period #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick,
  input  logic [W-1:0] period,
  output logic         expire
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  assign last   = (period == '0) ? '1 : period - 1'b1;
  assign expire = tick & (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (tick)   cnt_q <= expire ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/ptimer_wdt.sv
module ptimer_wdt #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  byte_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq,
  output logic        wdt_rst
);
  import ptimer_pkg::*;
  localparam int PS_W = DW - CNT_W;

  mode_t            mode_q, mode_d;
  logic             locked_q, locked_d;
  logic [ST_W-1:0]  flag_q, flag_set, flag_clr;
  logic [7:0]       cnt_byte [NB];
  logic [DW-1:0]    count_w;
  logic             wr_mode, wr_count, wr_stat;
  logic             en_rise, key_hit, reload;
  logic             tick, expire, bite;
  logic             mode_wdt, mode_en;
  logic             rst_q;

  assign wr_mode  = wr_en & (addr == A_MODE);
  assign wr_count = wr_en & (addr == A_COUNT);
  assign wr_stat  = wr_en & (addr == A_STAT);

  assign mode_wdt = mode_q.wdt;
  assign mode_en  = mode_q.en;

  // count word, byte-lane writes
  for (genvar b = 0; b < NB; b++) begin : g_cnt_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_byte[b] <= '0;
      else if (wr_count && byte_en[b])  cnt_byte[b] <= wdata[8*b +: 8];
    end
    assign count_w[8*b +: 8] = cnt_byte[b];
  end

  assign en_rise = wr_mode & byte_en[1] & wdata[B_EN] & ~mode_q.en;
  assign key_hit = wr_mode & byte_en[3] & (wdata[31:24] == SVC_KEY) &
                   mode_q.wdt & mode_q.en;
  assign reload  = (wr_count & (|byte_en)) | en_rise | key_hit;

  ptimer_prescaler #(.W(PS_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (mode_q.en),
    .clear   (reload),
    .div_val (count_w[DW-1:CNT_W]),
    .tick    (tick)
  );

  ptimer_period #(.W(CNT_W)) u_per (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (reload),
    .tick   (tick),
    .period (count_w[CNT_W-1:0]),
    .expire (expire)
  );

  assign bite = expire & mode_q.wdt;

  always_comb begin
    mode_d = mode_q;
    if (wr_mode && byte_en[1]) begin
      mode_d.irqen = wdata[B_IRQEN];
      mode_d.cont  = wdata[B_CONT];
      mode_d.en    = locked_q ? (mode_q.en | wdata[B_EN]) : wdata[B_EN];
      mode_d.wdt   = locked_q | wdata[B_WDT];
    end
    // one-shot and watchdog expiries stop the counter
    if (expire && (!mode_q.cont || mode_q.wdt)) mode_d.en = 1'b0;
    locked_d = locked_q | (mode_d.wdt & mode_d.en);
  end

  always_comb begin
    flag_set          = '0;
    flag_set[ST_EXP]  = expire;
    flag_set[ST_BITE] = bite;
    flag_clr = (wr_stat && byte_en[0]) ? wdata[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      locked_q <= 1'b0;
      flag_q   <= '0;
      rst_q    <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      locked_q <= locked_d;
      flag_q   <= (flag_q & ~flag_clr) | flag_set;
      rst_q    <= bite;
    end
  end

  assign irq     = flag_q[ST_EXP] & mode_q.irqen & ~mode_wdt;
  assign wdt_rst = rst_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE: begin
        rdata[B_WDT]   = mode_wdt;
        rdata[B_EN]    = mode_en;
        rdata[B_CONT]  = mode_q.cont;
        rdata[B_IRQEN] = mode_q.irqen;
      end
      A_COUNT: rdata = count_w;
      A_STAT:  rdata[ST_W-1:0] = flag_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ptimer_wdt_chk.sv
module ptimer_wdt_chk (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic wdt_rst,
  input logic flag_exp,
  input logic m_wdt,
  input logic m_en,
  input logic locked,
  input logic bite
);
  // R11
  rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  // R11
  rst_needs_wdt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> m_wdt);
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_exp && !m_wdt));
  // R12
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && m_wdt));
  // R12
  lock_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && m_en && !bite) |=> m_en);
endmodule

bind ptimer_wdt ptimer_wdt_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .wdt_rst  (wdt_rst),
  .flag_exp (flag_q[0]),
  .m_wdt    (mode_wdt),
  .m_en     (mode_en),
  .locked   (locked_q),
  .bite     (bite)
);

// File: tb/ptimer_wdt_bench.sv
`timescale 1ns/1ps
module ptimer_wdt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  byte_en = '0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wdt_rst;
  int n_chk = 0;
  int n_err = 0;

  ptimer_wdt u_ptimer_wdt (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .byte_en(byte_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wdt_rst(wdt_rst)
  );

  always #2 clk = ~clk;

  function automatic int unsigned span(input int unsigned ps, input int unsigned per);
    return (ps == 0 ? 65536 : ps) * (per == 0 ? 65536 : per);
  endfunction

  function automatic logic [31:0] mode_word(input bit wdt, en, cont, ie);
    logic [31:0] m = '0;
    m[15] = wdt; m[12] = en; m[10] = cont; m[8] = ie;
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    addr = a; byte_en = be; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; byte_en = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic expect_expiry(input int unsigned n, input string req);
    logic [31:0] v;
    if (n > 1) begin
      repeat (n - 1) @(negedge clk);
      rd(2'd2, v);
      chk({req, " flag before expiry"}, {31'd0, v[0]}, 32'd0);
    end
    @(negedge clk);
    rd(2'd2, v);
    chk({req, " flag at expiry"}, {31'd0, v[0]}, 32'd1);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog expired got hang exp completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 mode", v, 32'd0);
    rd(2'd1, v); chk("R1 count", v, 32'd0);
    rd(2'd2, v); chk("R1 status", v, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 wdt_rst", {31'd0, wdt_rst}, 32'd0);

    // R2 R4 R5 R9 random divider/period pairs
    for (int i = 0; i < 14; i++) begin
      int unsigned ps, per;
      bit cont, ie;
      ps = 1 + ($urandom % 6);
      per = 1 + ($urandom % 6);
      cont = $urandom % 2;
      ie = $urandom % 2;
      wr(2'd1, 4'hF, {ps[15:0], per[15:0]});
      wr(2'd0, 4'h3, mode_word(0, 1, cont, ie));
      expect_expiry(span(ps, per), "R2");
      chk("R9 irq follows flag", {31'd0, irq}, {31'd0, ie});
      if (!cont) begin
        rd(2'd0, v);
        chk("R5 enable cleared", v, mode_word(0, 0, 0, ie));
      end else begin
        wr(2'd0, 4'h3, 32'd0);
      end
      wr(2'd2, 4'h1, 32'hF);
      rd(2'd2, v); chk("R8 status cleared", v, 32'd0);
    end

    // R3 zero divider = 65536
    wr(2'd1, 4'hF, {16'd0, 16'd1});
    wr(2'd0, 4'h3, mode_word(0, 1, 0, 0));
    expect_expiry(span(0, 1), "R3 divider zero");
    wr(2'd2, 4'h1, 32'h1);
    // R3 zero period = 65536 ticks
    wr(2'd1, 4'hF, {16'd1, 16'd0});
    wr(2'd0, 4'h3, mode_word(0, 1, 0, 0));
    expect_expiry(span(1, 0), "R3 period zero");
    wr(2'd2, 4'h1, 32'h1);

    // R4 periodic reload, second expiry
    wr(2'd1, 4'hF, {16'd2, 16'd3});
    wr(2'd0, 4'h3, mode_word(0, 1, 1, 0));
    expect_expiry(6, "R4 first");
    wr(2'd2, 4'h1, 32'h1);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R4 before second", {31'd0, v[0]}, 32'd0);
    @(negedge clk);
    rd(2'd2, v); chk("R4 second expiry", {31'd0, v[0]}, 32'd1);
    wr(2'd0, 4'h3, 32'd0);
    wr(2'd2, 4'h1, 32'h1);

    // R5 one-shot gives no second expiry
    wr(2'd1, 4'hF, {16'd1, 16'd4});
    wr(2'd0, 4'h3, mode_word(0, 1, 0, 0));
    expect_expiry(4, "R5");
    wr(2'd2, 4'h1, 32'h1);
    repeat (12) @(negedge clk);
    rd(2'd2, v); chk("R5 no further expiry", v, 32'd0);

    // R6 clearing enable stops the timer
    wr(2'd1, 4'hF, {16'd1, 16'd20});
    wr(2'd0, 4'h3, mode_word(0, 1, 0, 0));
    repeat (5) @(negedge clk);
    wr(2'd0, 4'h3, 32'd0);
    repeat (30) @(negedge clk);
    rd(2'd2, v); chk("R6 stopped", v, 32'd0);

    // R7 count write restarts countdown
    wr(2'd1, 4'hF, {16'd2, 16'd5});
    wr(2'd0, 4'h3, mode_word(0, 1, 0, 0));
    repeat (4) @(negedge clk);
    wr(2'd1, 4'hF, {16'd2, 16'd5});
    expect_expiry(10, "R7");

    // R9 irq gated by enable bit 8
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(2'd0, 4'h3, mode_word(0, 0, 0, 1));
    chk("R9 irq unmasked", {31'd0, irq}, 32'd1);

    // R8 write-one-to-clear
    wr(2'd2, 4'h1, 32'h0);
    rd(2'd2, v); chk("R8 zero write keeps flag", v, 32'd1);
    wr(2'd2, 4'h1, 32'h1);
    rd(2'd2, v); chk("R8 one write clears", v, 32'd0);
    chk("R9 irq after clear", {31'd0, irq}, 32'd0);

    // R10 R11 R12 watchdog (locks until reset, so last)
    wr(2'd1, 4'hF, {16'd2, 16'd4});
    wr(2'd0, 4'h3, mode_word(1, 1, 0, 1));
    for (int k = 0; k < 3; k++) begin
      repeat (6) @(negedge clk);
      wr(2'd0, 4'h8, 32'hA500_0000);
      chk("R10 serviced no reset", {31'd0, wdt_rst}, 32'd0);
    end
    wr(2'd0, 4'h3, mode_word(0, 0, 0, 1));
    rd(2'd0, v);
    chk("R12 disarm ignored", v, mode_word(1, 1, 0, 1));
    wr(2'd0, 4'h8, 32'h5A00_0000);
    repeat (5) @(negedge clk);
    chk("R10 wrong key no restart", {31'd0, wdt_rst}, 32'd0);
    @(negedge clk);
    chk("R11 reset pulse", {31'd0, wdt_rst}, 32'd1);
    chk("R9 irq off in watchdog", {31'd0, irq}, 32'd0);
    rd(2'd2, v); chk("R11 bite flag", v, 32'd3);
    @(negedge clk);
    chk("R11 pulse one cycle", {31'd0, wdt_rst}, 32'd0);
    rd(2'd0, v); chk("R11 stopped", v, mode_word(1, 0, 0, 1));
    repeat (12) @(negedge clk);
    chk("R11 no second pulse", {31'd0, wdt_rst}, 32'd0);

    finish_run();
  end
endmodule